// File: doc/BRIEF.md
# Shared Output-Buffer / Attention Interrupt Line

This block drives one level-sensitive host interrupt from two independent sticky sources. The first source marks that the output buffer has been filled for the host. The second source marks that the management side is asking for the host's attention. Each source is armed only when an interrupt line is wired up (a static configuration input) and software has enabled interrupts.

Each source is cleared by a different host access. A read of the data port clears the buffer source. A read of the status port clears the attention source. The line stays asserted while either source is pending. The block also keeps the attention status bit that the host sees in its status register. The protocol state machine and the bus address decode live outside this block, and they feed it single-cycle strobes.

Top module: `host_irq_share`

## Requirements
- R1: After asynchronous reset (rst_ni low), irq_o and atn_status_o are 0 and no source is pending.
- R2: An obf_set_i pulse while irq_present_i=1 and irq_en_i=1 makes the buffer source pending, and irq_o is 1 after the next rising clock edge.
- R3: An obf_set_i pulse while irq_present_i=0 or irq_en_i=0 leaves the buffer source idle, so irq_o stays 0 when no other source is pending.
- R4: A data_rd_i pulse clears the buffer source at the next edge.
- R5: A status_rd_i pulse clears the attention source at the next edge. It does not change atn_status_o.
- R6: An atn_req_i pulse loads atn_val_i into atn_status_o at the next edge. This happens whatever the values of atn_irq_i, irq_en_i and irq_present_i.
- R7: An atn_req_i pulse with atn_val_i=1 makes the attention source pending only when atn_irq_i=1, irq_en_i=1 and irq_present_i=1.
- R8: An atn_req_i pulse with atn_val_i=0 clears atn_status_o and the attention source at the next edge.
- R9: irq_o is 1 exactly when at least one source is pending. It falls only after both sources have been cleared.
- R10: A change of irq_en_i, on its own, does not set or clear a source that is already pending.
- R11: When a source's set condition and its clearing read occur in the same cycle, the set wins and the source is pending afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| obf_set_i | input | 1 | Pulse: output buffer was just filled |
| data_rd_i | input | 1 | Pulse: host read of the data port |
| status_rd_i | input | 1 | Pulse: host read of the status port |
| atn_req_i | input | 1 | Pulse: attention update request |
| atn_val_i | input | 1 | New attention value carried by atn_req_i |
| atn_irq_i | input | 1 | Attention update may raise an interrupt |
| irq_en_i | input | 1 | Global interrupt enable |
| irq_present_i | input | 1 | Static: an interrupt line is wired |
| atn_status_o | output | 1 | Attention status bit for the host status register |
| irq_o | output | 1 | Shared level interrupt to the host |

## Verification
All state is one register deep, so every result is due one rising edge after its stimulus. This holds for both irq_o and atn_status_o. The bench changes inputs on the falling edge and compares on the following falling edge, which lies half a period after the edge that updates the outputs. Directed sequences cover the arming conditions, the clearing reads, same-cycle conflicts and enable toggling. Permuted sweeps then drive all 256 input combinations from changing pending states against an arithmetic model built from the requirements.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;
  localparam int unsigned SRC_CNT = 2;
  typedef enum int unsigned {
    SRC_OBF = 0,
    SRC_ATN = 1
  } irq_src_e;
endpackage

// File: rtl/irq_src_cell.sv
// One sticky interrupt source; a qualified set beats a same-cycle clear.
module irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_d_o,
  output logic pend_q_o
);
  logic pend_q;

  always_comb begin
    pend_d_o = pend_q;
    if (set_i && !pend_q) pend_d_o = 1'b1;
    else if (clr_i && !set_i) pend_d_o = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d_o;
  end

  assign pend_q_o = pend_q;
endmodule

// File: rtl/atn_status_reg.sv
module atn_status_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic val_i,
  output logic status_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    status_o <= 1'b0;
    else if (req_i) status_o <= val_i;
  end
endmodule

// File: rtl/irq_line_reg.sv
// Registers the OR of next-state pending flags so the line moves with them.
module irq_line_reg #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_d_i,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |pend_d_i;
  end
endmodule

// File: rtl/host_irq_share.sv
module host_irq_share #(
  parameter int unsigned NUM_SRC = host_irq_pkg::SRC_CNT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic obf_set_i,
  input  logic data_rd_i,
  input  logic status_rd_i,
  input  logic atn_req_i,
  input  logic atn_val_i,
  input  logic atn_irq_i,
  input  logic irq_en_i,
  input  logic irq_present_i,
  output logic atn_status_o,
  output logic irq_o
);
  import host_irq_pkg::*;

  logic               arm;
  logic [NUM_SRC-1:0] set_v;
  logic [NUM_SRC-1:0] clr_v;
  logic [NUM_SRC-1:0] pend_d;
  logic [NUM_SRC-1:0] pend_q;

  assign arm = irq_en_i & irq_present_i;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[SRC_OBF] = obf_set_i & arm;
    clr_v[SRC_OBF] = data_rd_i;
    set_v[SRC_ATN] = atn_req_i & atn_val_i & atn_irq_i & arm;
    clr_v[SRC_ATN] = status_rd_i | (atn_req_i & ~atn_val_i);
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_cell u_src (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_v[g]),
      .clr_i    (clr_v[g]),
      .pend_d_o (pend_d[g]),
      .pend_q_o (pend_q[g])
    );
  end

  atn_status_reg u_atn (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (atn_req_i),
    .val_i    (atn_val_i),
    .status_o (atn_status_o)
  );

  irq_line_reg #(.N(NUM_SRC)) u_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_d_i (pend_d),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/host_irq_share_chk.sv
module host_irq_share_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       obf_set_i,
  input logic       data_rd_i,
  input logic       status_rd_i,
  input logic       atn_req_i,
  input logic       atn_val_i,
  input logic       atn_irq_i,
  input logic       irq_en_i,
  input logic       irq_present_i,
  input logic       atn_status_o,
  input logic       irq_o,
  input logic [1:0] pend_q
);
  assert_obf_raise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (obf_set_i && irq_en_i && irq_present_i) |=> pend_q[0]);

  assert_obf_unarmed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (obf_set_i && !(irq_en_i && irq_present_i) && !pend_q[0]) |=> !pend_q[0]);

  assert_obf_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && !obf_set_i) |=> !pend_q[0]);

  assert_atn_read_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && !atn_req_i) |=> (!pend_q[1] && $stable(atn_status_o)));

  assert_atn_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    atn_req_i |=> (atn_status_o == $past(atn_val_i)));

  assert_atn_qual_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (atn_req_i && atn_val_i && !atn_irq_i && !pend_q[1]) |=> !pend_q[1]);

  assert_atn_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (atn_req_i && !atn_val_i) |=> (!atn_status_o && !pend_q[1]));

  assert_line_or_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (pend_q != 2'b00));

  assert_hold_obf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!obf_set_i && !data_rd_i) |=> $stable(pend_q[0]));

  assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (obf_set_i && data_rd_i && irq_en_i && irq_present_i) |=> pend_q[0]);
endmodule

bind host_irq_share host_irq_share_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .obf_set_i     (obf_set_i),
  .data_rd_i     (data_rd_i),
  .status_rd_i   (status_rd_i),
  .atn_req_i     (atn_req_i),
  .atn_val_i     (atn_val_i),
  .atn_irq_i     (atn_irq_i),
  .irq_en_i      (irq_en_i),
  .irq_present_i (irq_present_i),
  .atn_status_o  (atn_status_o),
  .irq_o         (irq_o),
  .pend_q        (pend_q)
);

// File: tb/host_irq_share_test.sv
`timescale 1ns/1ps
module host_irq_share_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic obf_set = 0, data_rd = 0, status_rd = 0, atn_req = 0;
  logic atn_val = 0, atn_irq = 0, irq_en = 0, irq_present = 0;
  logic atn_status, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // model state for sweeps
  logic m_obf = 0, m_atn = 0, m_stat = 0;

  always #2 clk = ~clk;

  host_irq_share uut (
    .clk_i(clk), .rst_ni(rst_n), .obf_set_i(obf_set), .data_rd_i(data_rd),
    .status_rd_i(status_rd), .atn_req_i(atn_req), .atn_val_i(atn_val),
    .atn_irq_i(atn_irq), .irq_en_i(irq_en), .irq_present_i(irq_present),
    .atn_status_o(atn_status), .irq_o(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // vector bits: {present,en,atn_irq,atn_val,atn_req,status_rd,data_rd,obf_set}
  task automatic apply(input logic [7:0] v);
    {irq_present, irq_en, atn_irq, atn_val, atn_req, status_rd, data_rd, obf_set} = v;
    @(negedge clk);
    {atn_req, status_rd, data_rd, obf_set} = 4'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {atn_req, status_rd, data_rd, obf_set} = 4'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_obf = 0; m_atn = 0; m_stat = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  localparam logic [7:0] ARM = 8'b1100_0000;

  initial begin
    @(negedge clk);
    chk("R1 irq in reset", irq, 1'b0);
    chk("R1 status in reset", atn_status, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    apply(ARM | 8'h01);              chk("R2 obf raise", irq, 1'b1);
    idle(2);                         chk("R2 obf sticky", irq, 1'b1);
    apply(ARM | 8'h02);              chk("R4 data read clears", irq, 1'b0);
    apply(8'b1000_0001);             chk("R3 obf disabled", irq, 1'b0);
    apply(8'b0100_0001);             chk("R3 obf not present", irq, 1'b0);

    apply(8'b0001_1000);             chk("R6 status set unarmed", atn_status, 1'b1);
    chk("R7 unarmed no irq", irq, 1'b0);
    apply(ARM | 8'b0001_1000);       chk("R7 no qualifier no irq", irq, 1'b0);
    apply(ARM | 8'b0011_1000);       chk("R7 qualified raise", irq, 1'b1);
    apply(ARM | 8'h04);              chk("R5 status read clears", irq, 1'b0);
    chk("R5 status bit kept", atn_status, 1'b1);

    apply(ARM | 8'b0011_1000);
    apply(ARM | 8'h01);              chk("R9 both pending", irq, 1'b1);
    apply(ARM | 8'h02);              chk("R9 one left", irq, 1'b1);
    apply(ARM | 8'h04);              chk("R9 both clear", irq, 1'b0);

    apply(ARM | 8'b0011_1000);       chk("R8 pre", irq, 1'b1);
    apply(ARM | 8'b0000_1000);       chk("R8 irq drop", irq, 1'b0);
    chk("R8 status drop", atn_status, 1'b0);

    apply(ARM | 8'h01);
    apply(8'b1000_0000);             chk("R10 disable keeps pending", irq, 1'b1);
    idle(2);                         chk("R10 still pending", irq, 1'b1);
    apply(8'b1000_0010);             chk("R10 read clears while disabled", irq, 1'b0);
    apply(ARM);                      chk("R10 enable raises nothing", irq, 1'b0);

    apply(ARM | 8'h03);              chk("R11 obf set beats read", irq, 1'b1);
    apply(ARM | 8'h02);
    apply(ARM | 8'b0011_1100);       chk("R11 atn set beats read", irq, 1'b1);
    apply(ARM | 8'h04);              chk("R11 cleanup", irq, 1'b0);

    apply(ARM | 8'b0011_1001);
    rst_n = 1'b0; #1;
    chk("R1 async reset irq", irq, 1'b0);
    chk("R1 async reset status", atn_status, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 nothing pending after reset", irq, 1'b0);

    // permuted sweeps checked against a requirement model (R2..R11, line R9)
    do_reset();
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 256; i++) begin
        logic [7:0] v;
        logic arm, oset, aset, aclr;
        v = 8'((i * (1 + 36 * p + 64 * (p & 1)) + 17 * p) & 255);
        apply(v);
        arm  = v[7] & v[6];
        oset = v[0] & arm;
        aset = v[3] & v[4] & v[5] & arm;
        aclr = v[2] | (v[3] & ~v[4]);
        m_obf  = oset ? 1'b1 : (v[1] ? 1'b0 : m_obf);
        m_atn  = aset ? 1'b1 : (aclr ? 1'b0 : m_atn);
        m_stat = v[3] ? v[4] : m_stat;
        chk("R9 sweep line", irq, m_obf | m_atn);
        chk("R6 sweep status", atn_status, m_stat);
      end
    end

    done = 1;
    summary();
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
    end
  end
endmodule